// File: doc/BRIEF.md
# Clock Select and Standby Controller

This block chooses the clock that paces the processor core and manages a pin-driven hardware stop of the fast oscillator. The core clock can come from three places: the fast oscillator at full rate, the fast oscillator at half rate, or the 32.768 kHz slow crystal. A separate clock-output pin can carry either oscillator divided by two or by four, or it can be held low. A 14-bit time base counter advances on every core clock and raises a one-cycle tick at the rising edge of a selectable counter bit.

The block runs on one sampling clock `clk` that is faster than both oscillators. Each oscillator enters as a level, passes through a synchronizer and is turned into rising-edge events. The core clock leaves the block as a one-cycle enable, `cpu_ce`. The downstream core uses it as the enable of its gated clock. `hs_osc_en` tells the analog oscillator cell whether the fast oscillator may run.

Configuration arrives as a valid/ready write. A write is taken in a cycle where `cfg_valid` and `cfg_ready` are both high. All fields of an accepted write load together. If the write changes the core clock source, `cfg_ready` drops. It stays low until the switch has been made at a point where both the old and the new clock are low. While `cfg_ready` is low, `cfg_valid` is ignored. The sender must hold its write until it sees `cfg_ready` high.

Top module: `clk_standby_ctl`

## Requirements
- R1: After reset the core clock is the fast oscillator divided by two, `clk_out` is low, `hs_osc_en` and `cfg_ready` are high, hardware stop is disabled and the time base uses n = 1.
- R2: `cfg_cpu_sel` encodes the core clock source as follows: 2'b00 gives one `cpu_ce` pulse per fast rising edge, 2'b01 gives one per second fast rising edge, and 2'b10 gives one per slow rising edge. The value 2'b11 leaves the source unchanged. `cpu_ce` is never high in two consecutive cycles.
- R3: A write that changes the source sets `cfg_ready` low. The new source takes effect only when the old and new clocks are both low. A `cfg_valid` pulse while `cfg_ready` is low changes nothing.
- R4: `cfg_out_sel` is split into three bits. Bit 2 enables the output. Bit 1 selects the slow oscillator when 1 and the fast oscillator when 0. Bit 0 selects divide by four when 1 and divide by two when 0. With bit 2 at 0, `clk_out` is low from the next cycle on.
- R5: The time base counter advances once per `cpu_ce`. A tap value t selects counter bit 2t+1, limited to bit 13, so n = t+1. `tb_tick` is high for one cycle at each rising edge of that bit.
- R6: With hardware stop enabled, a low level on `stop_n` drops `hs_osc_en`. While it is low, fast-derived core pulses and clock output stop, and slow-derived ones continue.
- R7: After `stop_n` returns high, `hs_osc_en` rises only on the fourth slow rising edge, counted from the release, with the count set by SETTLE_LS.
- R8: With hardware stop disabled (`cfg_stop_en` = 0 in the last accepted write), `stop_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than both oscillators |
| rst_n | input | 1 | Active-low reset |
| hs_osc | input | 1 | Fast oscillator level |
| ls_osc | input | 1 | Slow 32.768 kHz crystal level |
| stop_n | input | 1 | Hardware stop pin, active low |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_ready | output | 1 | Configuration write ready; low while a source switch is pending |
| cfg_cpu_sel | input | 2 | Core clock source code |
| cfg_out_sel | input | 3 | Clock-output enable, source and divider |
| cfg_tap | input | 3 | Time base tap index t (n = t+1) |
| cfg_stop_en | input | 1 | Hardware stop enable |
| cpu_ce | output | 1 | One-cycle core clock enable |
| clk_out | output | 1 | Divided clock-output pin |
| tb_tick | output | 1 | One-cycle time base tick |
| hs_osc_en | output | 1 | Fast oscillator run enable |

## Verification
The hardest situation to reach is a source switch that stalls. In that case `cfg_ready` stays low for many cycles, and a second write attempted during the stall must be dropped. The bench waits for its own slow crystal to rise, then requests the slow clock a few cycles later. At that point the synchronized slow level is still high, so the switch must wait for it to fall. During the wait the bench pulses a clock-output write and later confirms that the pin stayed low. The stop exit window is checked at two points. The first is after at most two slow edges, where the oscillator must still be held off. The second is after enough time for four slow edges, where it must be running again.

// File: rtl/clksb_pkg.sv
`timescale 1ns/1ps
package clksb_pkg;
  typedef enum logic [1:0] {
    SRC_HS  = 2'b00,
    SRC_HS2 = 2'b01,
    SRC_LS  = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_STOP,
    ST_SETTLE
  } stop_st_e;

  typedef struct packed {
    logic en;
    logic ls;
    logic div4;
  } clko_cfg_t;
endpackage

// File: rtl/clksb_sync.sv
`timescale 1ns/1ps
module clksb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clksb_src_switch.sv
`timescale 1ns/1ps
module clksb_src_switch import clksb_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_run,
  input  logic       hs_lvl,
  input  logic       hs_rise,
  input  logic       ls_lvl,
  input  logic       ls_rise,
  input  logic       req_valid,
  input  logic [1:0] req_sel,
  output logic       req_ready,
  output logic       cpu_ce
);
  src_e cur_q, pend_q, req_src;
  logic pend_vld_q, half_q;
  logic ce_now, cur_low, new_low, accept;

  always_comb begin
    case (cur_q)
      SRC_HS:  begin ce_now = hs_rise;           cur_low = ~hs_lvl; end
      SRC_HS2: begin ce_now = hs_rise & ~half_q; cur_low = ~half_q; end
      default: begin ce_now = ls_rise;           cur_low = ~ls_lvl; end
    endcase
    case (pend_q)
      SRC_HS:  new_low = ~hs_lvl;
      SRC_HS2: new_low = ~half_q;
      default: new_low = ~ls_lvl;
    endcase
  end

  assign req_src   = src_e'(req_sel);
  assign req_ready = ~pend_vld_q;
  assign accept    = req_valid & ~pend_vld_q & (req_sel != 2'b11) & (req_src != cur_q);
  assign cpu_ce    = ce_now;

  // divided fast clock is held low while the oscillator is stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (!hs_run) half_q <= 1'b0;
    else if (hs_rise) half_q <= ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= SRC_HS2;
      pend_q     <= SRC_HS2;
      pend_vld_q <= 1'b0;
    end else if (accept) begin
      pend_q     <= req_src;
      pend_vld_q <= 1'b1;
    end else if (pend_vld_q && cur_low && new_low && !ce_now) begin
      cur_q      <= pend_q;
      pend_vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/clksb_clkout.sv
`timescale 1ns/1ps
module clksb_clkout import clksb_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hs_rise,
  input  logic      ls_rise,
  input  clko_cfg_t cfg,
  output logic      clk_out
);
  logic [1:0] div_q;
  logic       step;

  assign step = cfg.ls ? ls_rise : hs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (!cfg.en) div_q <= '0;
    else if (step)    div_q <= div_q + 2'd1;
  end

  assign clk_out = cfg.div4 ? div_q[1] : div_q[0];
endmodule

// File: rtl/clksb_tbase.sv
`timescale 1ns/1ps
module clksb_tbase #(
  parameter int WIDTH = 14,
  parameter int SELW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic [SELW-1:0] tap_sel,
  output logic            tick
);
  localparam int IW = $clog2(WIDTH);

  logic [WIDTH-1:0] cnt_q;
  logic [IW-1:0]    idx;
  logic             tap_now, tap_d_q;

  function automatic int tap_bit(input logic [SELW-1:0] s);
    int b;
    b = 2 * int'(s) + 1;
    if (b > WIDTH - 1) b = WIDTH - 1;
    return b;
  endfunction

  assign idx     = IW'(tap_bit(tap_sel));
  assign tap_now = cnt_q[idx];
  assign tick    = tap_now & ~tap_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tap_d_q <= 1'b0;
    end else begin
      if (ce) cnt_q <= cnt_q + 1'b1;
      tap_d_q <= tap_now;
    end
  end
endmodule

// File: rtl/clk_standby_ctl.sv
`timescale 1ns/1ps
module clk_standby_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int TB_WIDTH    = 14,
  parameter int TAP_W       = 3,
  parameter int SETTLE_LS   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_osc,
  input  logic             ls_osc,
  input  logic             stop_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [1:0]       cfg_cpu_sel,
  input  logic [2:0]       cfg_out_sel,
  input  logic [TAP_W-1:0] cfg_tap,
  input  logic             cfg_stop_en,
  output logic             cpu_ce,
  output logic             clk_out,
  output logic             tb_tick,
  output logic             hs_osc_en
);
  import clksb_pkg::*;

  localparam int SCW = $clog2(SETTLE_LS + 1);

  logic hs_raw, ls_lvl, stop_lvl;
  logic hs_prev_q, ls_prev_q;
  logic hs_run, hs_lvl, hs_rise, ls_rise, cfg_fire;
  clko_cfg_t        out_q;
  logic [TAP_W-1:0] tap_q;
  logic             stop_en_q;
  stop_st_e         st_q;
  logic [SCW-1:0]   set_cnt_q;

  clksb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hs_sync (
    .clk(clk), .rst_n(rst_n), .d(hs_osc), .q(hs_raw));
  clksb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ls_sync (
    .clk(clk), .rst_n(rst_n), .d(ls_osc), .q(ls_lvl));
  clksb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d(stop_n), .q(stop_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev_q <= 1'b0;
      ls_prev_q <= 1'b0;
    end else begin
      hs_prev_q <= hs_raw;
      ls_prev_q <= ls_lvl;
    end
  end

  assign hs_run    = (st_q == ST_RUN);
  assign hs_lvl    = hs_raw & hs_run;
  assign hs_rise   = hs_raw & ~hs_prev_q & hs_run;
  assign ls_rise   = ls_lvl & ~ls_prev_q;
  assign hs_osc_en = hs_run;
  assign cfg_fire  = cfg_valid & cfg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      tap_q     <= '0;
      stop_en_q <= 1'b0;
    end else if (cfg_fire) begin
      out_q     <= clko_cfg_t'(cfg_out_sel);
      tap_q     <= cfg_tap;
      stop_en_q <= cfg_stop_en;
    end
  end

  // hardware stop: enter on pin low, leave after SETTLE_LS slow edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      set_cnt_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: if (stop_en_q && !stop_lvl) st_q <= ST_STOP;
        ST_STOP: if (stop_lvl) begin
          st_q      <= ST_SETTLE;
          set_cnt_q <= '0;
        end
        default: begin
          if (stop_en_q && !stop_lvl) st_q <= ST_STOP;
          else if (ls_rise) begin
            if (set_cnt_q == SCW'(SETTLE_LS - 1)) st_q <= ST_RUN;
            else set_cnt_q <= set_cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  clksb_src_switch u_switch (
    .clk(clk), .rst_n(rst_n), .hs_run(hs_run), .hs_lvl(hs_lvl), .hs_rise(hs_rise),
    .ls_lvl(ls_lvl), .ls_rise(ls_rise), .req_valid(cfg_valid), .req_sel(cfg_cpu_sel),
    .req_ready(cfg_ready), .cpu_ce(cpu_ce));

  clksb_clkout u_clkout (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .ls_rise(ls_rise),
    .cfg(out_q), .clk_out(clk_out));

  clksb_tbase #(.WIDTH(TB_WIDTH), .SELW(TAP_W)) u_tbase (
    .clk(clk), .rst_n(rst_n), .ce(cpu_ce), .tap_sel(tap_q), .tick(tb_tick));
endmodule

// File: rtl/clksb_checker.sv
`timescale 1ns/1ps
module clksb_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_ce,
  input logic tb_tick,
  input logic cfg_valid,
  input logic cfg_ready,
  input logic hs_osc_en,
  input logic clk_out,
  input logic ls_rise,
  input logic stop_lvl,
  input logic stop_en_q,
  input logic out_en
);
  a_r2_ce_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |=> !cpu_ce);

  a_r3_ready_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_ready) |-> $past(cfg_valid));

  a_r4_disabled_output_low: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !clk_out);

  a_r5_tick_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tb_tick |=> !tb_tick);

  a_r6_stop_needs_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_osc_en) |-> $past(!stop_lvl));

  a_r7_wake_on_slow_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_osc_en) |-> $past(ls_rise));

  a_r8_stop_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_osc_en) |-> $past(stop_en_q));
endmodule

bind clk_standby_ctl clksb_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .tb_tick(tb_tick),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .hs_osc_en(hs_osc_en),
  .clk_out(clk_out), .ls_rise(ls_rise), .stop_lvl(stop_lvl),
  .stop_en_q(stop_en_q), .out_en(out_q.en));

// File: tb/clk_standby_ctl_tb_top.sv
`timescale 1ns/1ps
module clk_standby_ctl_tb_top;
  localparam int WIN = 1280;

  logic       clk = 1'b0, rst_n = 1'b0, hs_osc = 1'b0, ls_osc = 1'b0, stop_n = 1'b1;
  logic       cfg_valid = 1'b0, cfg_stop_en = 1'b0;
  logic [1:0] cfg_cpu_sel = 2'b00;
  logic [2:0] cfg_out_sel = 3'b000, cfg_tap = 3'b000;
  logic       cfg_ready, cpu_ce, clk_out, tb_tick, hs_osc_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;      // 200 MHz
  always #10  hs_osc = ~hs_osc; // 4 clk period
  always #100 ls_osc = ~ls_osc; // 40 clk period

  clk_standby_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .hs_osc(hs_osc), .ls_osc(ls_osc), .stop_n(stop_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_cpu_sel(cfg_cpu_sel),
    .cfg_out_sel(cfg_out_sel), .cfg_tap(cfg_tap), .cfg_stop_en(cfg_stop_en),
    .cpu_ce(cpu_ce), .clk_out(clk_out), .tb_tick(tb_tick), .hs_osc_en(hs_osc_en));

  typedef struct packed {
    logic [1:0] sel;
    logic [2:0] outs;
    logic [2:0] tap;
    int         ce;
    int         co;
    int         tk;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b00, 3'b100, 3'd0, 320, 160, 80},
    '{2'b01, 3'b101, 3'd0, 160,  80, 40},
    '{2'b10, 3'b110, 3'd0,  32,  16,  8},
    '{2'b00, 3'b111, 3'd1, 320,   8, 20},
    '{2'b00, 3'b000, 3'd2, 320,   0,  5},
    '{2'b01, 3'b011, 3'd1, 160,   0, 10},
    '{2'b11, 3'b100, 3'd0, 160, 160, 40}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [2:0] o,
                           input logic [2:0] t, input logic e);
    while (!cfg_ready) @(negedge clk);
    cfg_cpu_sel = s; cfg_out_sel = o; cfg_tap = t; cfg_stop_en = e;
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic window(output int ce, output int co, output int tk);
    logic prev;
    ce = 0; co = 0; tk = 0;
    prev = clk_out;
    repeat (WIN) begin
      @(posedge clk); #1;
      if (cpu_ce) ce++;
      if (clk_out && !prev) co++;
      prev = clk_out;
      if (tb_tick) tk++;
    end
    @(negedge clk);
  endtask

  initial begin
    int ce, co, tk;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cfg_ready after reset", int'(cfg_ready), 1);
    check("R1 hs_osc_en after reset", int'(hs_osc_en), 1);
    check("R1 clk_out after reset", int'(clk_out), 0);
    repeat (20) @(negedge clk);
    window(ce, co, tk);
    check("R1 default source fast/2", ce, 160);
    check("R1 default output off", co, 0);
    check("R1 default tap n=1", tk, 40);

    // R2 R4 R5 vector table
    for (int i = 0; i < 7; i++) begin
      cfg_write(VECS[i].sel, VECS[i].outs, VECS[i].tap, 1'b0);
      repeat (200) @(negedge clk);
      window(ce, co, tk);
      check($sformatf("R2 vec%0d cpu_ce", i), ce, VECS[i].ce);
      check($sformatf("R4 vec%0d clk_out", i), co, VECS[i].co);
      check($sformatf("R5 vec%0d tick", i), tk, VECS[i].tk);
    end

    // R3 stalled switch and rejected write
    cfg_write(2'b00, 3'b000, 3'd0, 1'b0);
    repeat (200) @(negedge clk);
    @(posedge ls_osc);
    repeat (5) @(negedge clk);
    cfg_write(2'b10, 3'b000, 3'd0, 1'b0);
    check("R3 ready low while switch pending", int'(cfg_ready), 0);
    cfg_cpu_sel = 2'b11; cfg_out_sel = 3'b100; cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    repeat (40) @(negedge clk);
    check("R3 ready back after switch", int'(cfg_ready), 1);
    window(ce, co, tk);
    check("R3 slow source applied", ce, 32);
    check("R3 write while not ready ignored", co, 0);

    // R6 R7 hardware stop with slow core clock
    cfg_write(2'b10, 3'b100, 3'd0, 1'b1);
    repeat (200) @(negedge clk);
    stop_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 hs_osc_en low in stop", int'(hs_osc_en), 0);
    window(ce, co, tk);
    check("R6 slow core clock continues", ce, 32);
    check("R6 fast clock output frozen", co, 0);
    stop_n = 1'b1;
    repeat (60) @(negedge clk);
    check("R7 still settling", int'(hs_osc_en), 0);
    repeat (160) @(negedge clk);
    check("R7 fast oscillator resumed", int'(hs_osc_en), 1);
    repeat (50) @(negedge clk);
    window(ce, co, tk);
    check("R7 fast clock output back", co, 160);

    // R8 stop pin ignored when disabled
    cfg_write(2'b10, 3'b100, 3'd0, 1'b0);
    repeat (50) @(negedge clk);
    stop_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 hs_osc_en stays high", int'(hs_osc_en), 1);
    window(ce, co, tk);
    check("R8 fast clock output unaffected", co, 160);
    stop_n = 1'b1;

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule